// File: doc/BRIEF.md
# Key-Sequence Lock Gate for a Register-Bank Paging Control

This block watches the bytes that software writes to a single I/O port, one byte for each cycle in which the write strobe is high. It grants or removes the right to page a memory-mapped register bank in and out. The bytes must form a defined pattern:

1. A synchronising pair: a nonzero byte, then a zero byte.
2. A fixed 13-byte key.
3. A decision byte. The value CD requests unlock and any other value requests lock.
4. One more commit byte of any value. Only this byte changes the lock state.

The recognizer follows the stream continuously. Zero and nonzero bytes steer it differently at each stage, so a stray byte in the stream brings it back into step and does not jam it.

The block's output is a lock flag, and that flag gates a single paging control bit. While the flag is set, writes to the paging control are dropped. The bank mapping therefore stays in whatever state it held when locking took effect: if the bank was paged in, it stays paged in. Everything else on the chip is outside this block. The I/O address decode is reduced to a plain write strobe.

Top module: `key_unlock_gate`

## Requirements
- R1: Synchronisation needs a nonzero byte followed by a zero byte. Nonzero bytes that arrive while the zero is awaited keep the machine waiting for the zero.
- R2: Once synchronised, the key is the 13 bytes FF, 77, B3, 51, A8, D4, 62, 39, 9C, 46, 2B, 15, 8A, in that order.
- R3: While the first key byte (FF) is awaited, a zero byte keeps the machine synchronised. Any other nonzero byte counts as a new first sync byte, so the machine then waits for a zero again.
- R4: During key matching, a zero byte sends the machine back to awaiting FF. A nonzero byte that does not match sends it back to awaiting the zero sync byte.
- R5: The byte after a complete key decides the outcome: CD (hex) means unlock and any other value means lock. The commit byte applies that outcome, and `locked` shows it one clock after the commit byte is accepted.
- R6: `locked` keeps its value through the decision byte. It changes only on the clock that accepts the commit byte.
- R7: Synchronous reset sets `locked` to 1 and `page_en` to 0.
- R8: A `page_wr` strobe copies `page_en_in` into `page_en` only when `locked` is 0 at that clock edge. While `locked` is 1, `page_en` holds its value.
- R9: After the commit byte, the machine awaits a zero sync byte if the commit byte was nonzero. If the commit byte was zero, it awaits a nonzero sync byte.
- R10: A reset that arrives after the decision byte and before the commit byte discards the decision. A later byte then does not change `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe for the key port |
| wr_data | input | 8 | Byte written to the key port |
| page_wr | input | 1 | Write strobe for the paging control |
| page_en_in | input | 1 | Requested paging state |
| locked | output | 1 | 1 while paging control writes are blocked |
| page_en | output | 1 | Register bank paged in when 1 |

## Verification
The bench interrupts the sequence at each stage and checks how the machine recovers:
- A second nonzero byte during synchronisation must not break the sync. A design that treats it as a break would never unlock.
- A stray nonzero byte before FF must force a fresh zero. A design that forgets this would accept a key that should be rejected.
- A zero byte in the middle of the key must allow an immediate restart at FF. A design that sends it to the wrong wait state misses the key that follows.
- A wrong byte in the middle of the key must be refused.

The bench also checks the timing of the change. After the decision byte alone, `locked` must not move, so a design that applies the decision early fails there. It also checks the lingering effects. After relocking, an attempt to page the bank out must have no effect. A decision left pending across a reset must not be applied by the next byte.

// File: rtl/keygate_pkg.sv
package keygate_pkg;
  localparam int KEY_LEN = 13;
  localparam int POS_W   = $clog2(KEY_LEN);

  typedef enum logic [2:0] {
    ST_WAIT_NZ,
    ST_WAIT_ZERO,
    ST_WAIT_FIRST,
    ST_MATCH,
    ST_DECIDE,
    ST_COMMIT
  } seq_state_e;

  function automatic logic [7:0] key_byte(input int idx);
    case (idx)
      0:  key_byte = 8'hFF;
      1:  key_byte = 8'h77;
      2:  key_byte = 8'hB3;
      3:  key_byte = 8'h51;
      4:  key_byte = 8'hA8;
      5:  key_byte = 8'hD4;
      6:  key_byte = 8'h62;
      7:  key_byte = 8'h39;
      8:  key_byte = 8'h9C;
      9:  key_byte = 8'h46;
      10: key_byte = 8'h2B;
      11: key_byte = 8'h15;
      12: key_byte = 8'h8A;
      default: key_byte = 8'h00;
    endcase
  endfunction

  function automatic logic wants_unlock(input logic [7:0] b);
    return b == 8'hCD;
  endfunction
endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
  import keygate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       decide_fire,
  output logic       decide_unlock,
  output logic       commit_fire
);
  seq_state_e       state;
  logic [POS_W-1:0] pos;
  logic             byte_zero;
  logic             key_hit;
  logic             key_last;

  assign byte_zero     = (wr_data == 8'h00);
  assign key_hit       = (wr_data == key_byte(int'(pos)));
  assign key_last      = (pos == POS_W'(KEY_LEN - 1));
  assign decide_fire   = wr_en && (state == ST_DECIDE);
  assign decide_unlock = wants_unlock(wr_data);
  assign commit_fire   = wr_en && (state == ST_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT_NZ;
      pos   <= '0;
    end else if (wr_en) begin
      case (state)
        ST_WAIT_NZ:
          if (!byte_zero) state <= ST_WAIT_ZERO;
        ST_WAIT_ZERO:
          if (byte_zero) state <= ST_WAIT_FIRST;
        ST_WAIT_FIRST: begin
          pos <= '0;
          if (wr_data == key_byte(0)) begin
            state <= ST_MATCH;
            pos   <= POS_W'(1);
          end else if (!byte_zero) begin
            state <= ST_WAIT_ZERO;
          end
        end
        ST_MATCH: begin
          if (byte_zero) begin
            state <= ST_WAIT_FIRST;
            pos   <= '0;
          end else if (key_hit) begin
            if (key_last) begin
              state <= ST_DECIDE;
              pos   <= '0;
            end else begin
              pos <= pos + POS_W'(1);
            end
          end else begin
            state <= ST_WAIT_ZERO;
            pos   <= '0;
          end
        end
        ST_DECIDE:
          state <= ST_COMMIT;
        ST_COMMIT:
          state <= byte_zero ? ST_WAIT_NZ : ST_WAIT_ZERO;
        default: begin
          state <= ST_WAIT_NZ;
          pos   <= '0;
        end
      endcase
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    pos < POS_W'(KEY_LEN)); // R2

  AST_DECIDE_THEN_COMMIT: assert property (@(posedge clk) disable iff (rst)
    decide_fire |=> (state == ST_COMMIT)); // R6

  AST_COMMIT_NZ_RETURN: assert property (@(posedge clk) disable iff (rst)
    (commit_fire && !byte_zero) |=> (state == ST_WAIT_ZERO)); // R9

  AST_COMMIT_Z_RETURN: assert property (@(posedge clk) disable iff (rst)
    (commit_fire && byte_zero) |=> (state == ST_WAIT_NZ)); // R9
endmodule

// File: rtl/lock_holder.sv
module lock_holder (
  input  logic clk,
  input  logic rst,
  input  logic decide_fire,
  input  logic decide_unlock,
  input  logic commit_fire,
  output logic locked
);
  logic pend_unlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_unlock <= 1'b0;
      locked      <= 1'b1;
    end else begin
      if (decide_fire) pend_unlock <= decide_unlock;
      if (commit_fire) locked <= !pend_unlock;
    end
  end

  AST_LOCK_STEADY: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(locked)); // R6

  AST_UNLOCK_APPLIED: assert property (@(posedge clk) disable iff (rst)
    (commit_fire && pend_unlock) |=> !locked); // R5
endmodule

// File: rtl/page_gate.sv
module page_gate (
  input  logic clk,
  input  logic rst,
  input  logic locked,
  input  logic page_wr,
  input  logic page_en_in,
  output logic page_en
);
  logic page_wr_ok;

  assign page_wr_ok = page_wr && !locked;

  always_ff @(posedge clk) begin
    if (rst)             page_en <= 1'b0;
    else if (page_wr_ok) page_en <= page_en_in;
  end

  AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(page_en)); // R8
endmodule

// File: rtl/key_unlock_gate.sv
module key_unlock_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       page_wr,
  input  logic       page_en_in,
  output logic       locked,
  output logic       page_en
);
  logic decide_fire;
  logic decide_unlock;
  logic commit_fire;

  key_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .decide_fire  (decide_fire),
    .decide_unlock(decide_unlock),
    .commit_fire  (commit_fire)
  );

  lock_holder u_lock (
    .clk          (clk),
    .rst          (rst),
    .decide_fire  (decide_fire),
    .decide_unlock(decide_unlock),
    .commit_fire  (commit_fire),
    .locked       (locked)
  );

  page_gate u_page (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked),
    .page_wr   (page_wr),
    .page_en_in(page_en_in),
    .page_en   (page_en)
  );
endmodule

// File: tb/key_unlock_gate_bench.sv
module key_unlock_gate_bench;
  localparam time CLK_HALF = 4ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       page_wr = 1'b0;
  logic       page_en_in = 1'b0;
  logic       locked;
  logic       page_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] key [13] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                           8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A};

  key_unlock_gate u_key_unlock_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .page_wr(page_wr), .page_en_in(page_en_in),
    .locked(locked), .page_en(page_en)
  );

  always #CLK_HALF clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic put_key_from(input int first);
    for (int i = first; i < 13; i++) put(key[i]);
  endtask

  task automatic page(input logic v);
    @(negedge clk);
    page_wr = 1'b1; page_en_in = v;
    @(posedge clk); #1;
    page_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R7 locked after reset", locked, 1'b1);
    check("R7 page_en after reset", page_en, 1'b0);
    page(1'b1);
    check("R8 page write ignored while locked", page_en, 1'b0);
  endtask

  task automatic t_unlock_and_page();
    put(8'h55); put(8'h00); put_key_from(0); put(8'hCD);
    check("R6 no change on decision byte", locked, 1'b1);
    put(8'h00);
    check("R5 unlock after commit", locked, 1'b0);
    page(1'b1);
    check("R8 page in while unlocked", page_en, 1'b1);
    page(1'b0);
    check("R8 page out while unlocked", page_en, 1'b0);
    page(1'b1);
  endtask

  task automatic t_lock_freezes();
    // state awaits nonzero (commit was 00, R9)
    put(8'h21); put(8'h00); put_key_from(0); put(8'h11);
    check("R6 still unlocked after lock decision", locked, 1'b0);
    put(8'h22);
    check("R5 lock after commit", locked, 1'b1);
    page(1'b0);
    check("R8 mapping frozen on while locked", page_en, 1'b1);
  endtask

  task automatic t_sync_repeat_nz();
    // commit 22 was nonzero: awaiting zero (R9)
    put(8'h12); put(8'h34); put(8'h00); put_key_from(0); put(8'hCD); put(8'h07);
    check("R1 repeated nonzero keeps sync wait", locked, 1'b0);
  endtask

  task automatic t_zeros_before_key();
    // commit 07 nonzero: awaiting zero (R9)
    put(8'h00); put(8'h00); put(8'h00); put_key_from(0); put(8'h00); put(8'h00);
    check("R3 zeros keep sync; R5 zero decision locks", locked, 1'b1);
  endtask

  task automatic t_stray_before_key();
    // commit 00: awaiting nonzero (R9)
    put(8'h01); put(8'h00); put(8'h44); put_key_from(0); put(8'hCD); put(8'h00);
    check("R3 stray byte before FF rejects key", locked, 1'b1);
    // the final 00 completed a new sync
    put_key_from(0); put(8'hCD); put(8'h01);
    check("R3 key after resync accepted", locked, 1'b0);
  endtask

  task automatic t_zero_mid_key();
    // awaiting zero
    put(8'h00); put(8'hFF); put(8'h77); put(8'h00);
    put_key_from(0); put(8'h33); put(8'h44);
    check("R4 zero mid key restarts at FF", locked, 1'b1);
  endtask

  task automatic t_mismatch_mid_key();
    // awaiting zero
    put(8'h00); put(8'hFF); put(8'h77); put(8'hB3); put(8'h99);
    put_key_from(3); put(8'hCD); put(8'h00);
    check("R4 mismatch aborts key", locked, 1'b1);
    // final 00 gave sync; next key is accepted
    put_key_from(0); put(8'hCD); put(8'h00);
    check("R2 full key after mismatch accepted", locked, 1'b0);
  endtask

  task automatic t_reset_discards();
    do_reset();
    check("R7 reset relocks", locked, 1'b1);
    check("R7 reset clears page_en", page_en, 1'b0);
    put(8'h01); put(8'h00); put_key_from(0); put(8'hCD);
    do_reset();
    put(8'h55);
    check("R10 pending unlock discarded by reset", locked, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset_state();
    t_unlock_and_page();
    t_lock_freezes();
    t_sync_repeat_nz();
    t_zeros_before_key();
    t_stray_before_key();
    t_zero_mid_key();
    t_mismatch_mid_key();
    t_reset_discards();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_HALF * 2 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule